// File: doc/BRIEF.md
# Oversampled SPI Byte Receiver

This block receives serial data from an SPI master and hands complete bytes to the logic behind it. The serial clock, the active-low chip select and the data line are never used as clocks. All three are treated as ordinary inputs: each is resynchronised into the fast system clock domain, and SCK rising edges are found by comparing two consecutive samples.

Once eight rising edges have been qualified inside one chip-select window, the assembled byte appears on the output together with a strobe that lasts exactly one system clock cycle. A second flag, aligned with the strobe, marks the first byte of the current frame. The receiver works in mode 0 only, shifts the most significant bit first, and has no transmit path.

The system clock must run at least four times faster than SCK. For example, a 100 MHz system clock supports SCK at 25 MHz.

Top module: `spi_rx_oversampled`

## Requirements
- R1: Each pin passes through two system-clock flip-flops before any logic uses it. If the 8th SCK rise is driven just after an edge, the strobe is visible after the third system clock edge that follows.
- R2: A bit is taken only where the synchronised SCK is high and the previous sample was low. Holding SCK high or low for many system clocks adds no extra bits.
- R3: An edge counts only when the synchronised chip select is low in both the current and the previous sample. SCK activity while chip select is high produces no byte. A rising SCK in the same sample as the chip-select fall is not counted.
- R4: The data line is sampled at each counted edge and shifted in most significant bit first. `byte_out` carries the eight bits in arrival order, first bit at bit 7. `byte_out` changes only together with a strobe and otherwise holds the last byte.
- R5: `byte_valid` is high for exactly one system clock cycle per completed byte.
- R6: `byte_first` is high together with the strobe only for the first byte after chip select falls, and is low at all other times.
- R7: While the synchronised chip select is high, the bit count and the shift register are cleared. A partial byte is dropped without a strobe, and the next frame starts from bit 7.
- R8: An active-low asynchronous reset clears the synchroniser history to the idle pin state (SCK low, chip select high), clears the counters and flags, and sets `byte_out` to 0.
- R9: With SCK at four system clocks per period (two high, two low), consecutive bytes in one frame are all received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck_pin | input | 1 | Serial clock from the master, asynchronous |
| csn_pin | input | 1 | Active-low chip select, asynchronous |
| mosi_pin | input | 1 | Serial data from the master, asynchronous |
| byte_out | output | 8 | Last received byte, first bit at bit 7 |
| byte_valid | output | 1 | One-cycle strobe for a new byte |
| byte_first | output | 1 | Set with the strobe on the first byte of a frame |

## Verification
The receiver is driven with several kinds of traffic:
- A back-to-back frame at the fastest SCK ratio. This separates correct edge finding from missed or doubled bits.
- A slow SCK with a long high phase. This shows whether a level is being counted instead of an edge.
- SCK toggling while chip select is high, and a chip-select fall that coincides with an SCK rise. These test the qualification on both samples.
- A frame cut off mid-byte and then restarted, and a reset applied mid-frame. These show whether stale bits leak into the next byte.

A behavioural model with its own sample history predicts the outputs on every clock, and per-scenario checks confirm byte values, first-byte flags and the strobe latency.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef struct packed {
    logic sck;
    logic csn;
    logic mosi;
  } pin_t;

  localparam pin_t PIN_IDLE = '{sck: 1'b0, csn: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_head
      assign stage_d = d;
    end else begin : g_tail
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/edge_qual.sv
module edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic csn_s,
  input  logic mosi_s,
  output logic hit,
  output logic cs_fall,
  output logic cs_idle,
  output logic bit_o
);
  logic sck_p_q, csn_p_q;
  logic sck_p_d, csn_p_d;

  always_comb begin
    sck_p_d = sck_s;
    csn_p_d = csn_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p_q <= 1'b0;
      csn_p_q <= 1'b1;
    end else begin
      sck_p_q <= sck_p_d;
      csn_p_q <= csn_p_d;
    end
  end

  assign hit     = sck_s && !sck_p_q && !csn_s && !csn_p_q;
  assign cs_fall = !csn_s && csn_p_q;
  assign cs_idle = csn_s;
  assign bit_o   = mosi_s;
endmodule

// File: rtl/byte_assembler.sv
module byte_assembler #(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              bit_in,
  input  logic              cs_fall,
  input  logic              cs_idle,
  output logic [WORD_W-1:0] data,
  output logic              valid,
  output logic              first,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d, word_next;
  logic [WORD_W-1:0] data_q;
  logic              load_en;
  logic              valid_q, valid_d;
  logic              first_q, first_d;
  logic              pend_q, pend_d;

  assign word_next = {sh_q[WORD_W-2:0], bit_in};

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    pend_d  = pend_q;
    load_en = 1'b0;
    valid_d = 1'b0;
    first_d = 1'b0;
    if (cs_fall) pend_d = 1'b1;
    if (cs_idle) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (hit) begin
      sh_d = word_next;
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        load_en = 1'b1;
        valid_d = 1'b1;
        first_d = pend_q;
        pend_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
      first_q <= first_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= word_next;
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign first = first_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_rx_oversampled.sv
module spi_rx_oversampled
  import spi_rx_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_pin,
  input  logic              csn_pin,
  input  logic              mosi_pin,
  output logic [WORD_W-1:0] byte_out,
  output logic              byte_valid,
  output logic              byte_first
);
  localparam int CNT_W = $clog2(WORD_W);

  pin_t             raw_pins, sync_pins;
  logic             edge_hit, cs_fall, cs_idle, data_bit;
  logic [CNT_W-1:0] bit_cnt;

  assign raw_pins = '{sck: sck_pin, csn: csn_pin, mosi: mosi_pin};

  pin_sync #(
    .WIDTH  ($bits(pin_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_pins),
    .q    (sync_pins)
  );

  edge_qual u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_s  (sync_pins.sck),
    .csn_s  (sync_pins.csn),
    .mosi_s (sync_pins.mosi),
    .hit    (edge_hit),
    .cs_fall(cs_fall),
    .cs_idle(cs_idle),
    .bit_o  (data_bit)
  );

  byte_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (edge_hit),
    .bit_in (data_bit),
    .cs_fall(cs_fall),
    .cs_idle(cs_idle),
    .data   (byte_out),
    .valid  (byte_valid),
    .first  (byte_first),
    .cnt_o  (bit_cnt)
  );
endmodule

// File: rtl/spi_rx_checker.sv
module spi_rx_checker #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] byte_out,
  input logic              byte_valid,
  input logic              byte_first,
  input logic              cs_idle,
  input logic              hit,
  input logic [CNT_W-1:0]  bit_cnt
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  a_r6_first_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    byte_first |-> byte_valid);

  a_r4_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_out) |-> byte_valid);

  a_r7_idle_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (bit_cnt == '0));

  a_r2_count_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bit_cnt) && bit_cnt != '0) |-> $past(hit));
endmodule

bind spi_rx_oversampled spi_rx_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_out  (byte_out),
  .byte_valid(byte_valid),
  .byte_first(byte_first),
  .cs_idle   (cs_idle),
  .hit       (edge_hit),
  .bit_cnt   (bit_cnt)
);

// File: tb/tb_spi_rx_oversampled.sv
module tb_spi_rx_oversampled;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sck_pin, csn_pin, mosi_pin;
  logic [7:0] byte_out;
  logic       byte_valid, byte_first;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  spi_rx_oversampled dut (
    .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .csn_pin(csn_pin),
    .mosi_pin(mosi_pin), .byte_out(byte_out), .byte_valid(byte_valid),
    .byte_first(byte_first)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: sample history {sck,csn,mosi}, newest first
  logic [2:0] hq[$];
  int   m_cnt, m_acc, m_pend, m_byte, m_valid, m_first;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = '{3'b010, 3'b010, 3'b010};
      m_cnt = 0; m_acc = 0; m_pend = 0; m_byte = 0; m_valid = 0; m_first = 0;
    end else begin
      logic [2:0] cur, prv;
      cur = hq[1];
      prv = hq[2];
      m_valid = 0;
      m_first = 0;
      if (!cur[1] && prv[1]) m_pend = 1;
      if (cur[1]) begin
        m_cnt = 0; m_acc = 0;
      end else if (cur[2] && !prv[2] && !prv[1]) begin
        m_acc = ((m_acc << 1) | cur[0]) & 8'hFF;
        m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0; m_byte = m_acc; m_valid = 1; m_first = m_pend; m_pend = 0;
        end
      end
      hq.push_front({sck_pin, csn_pin, mosi_pin});
      void'(hq.pop_back());
    end
  end

  logic [7:0] got_b[$];
  bit         got_f[$];
  int         got_c[$];

  always @(posedge clk) begin
    cyc++;
    #5;
    if (rst_n) begin
      chk(byte_valid == m_valid[0], "R5", "strobe vs model", byte_valid, m_valid);
      chk(byte_out == m_byte[7:0], "R4", "byte vs model", byte_out, m_byte);
      chk(byte_first == m_first[0], "R6", "first flag vs model", byte_first, m_first);
      if (byte_valid) begin
        got_b.push_back(byte_out);
        got_f.push_back(byte_first);
        got_c.push_back(cyc);
      end
    end
  end

  task automatic put(input logic s, input logic c, input logic m, input int n);
    @(negedge clk);
    sck_pin = s; csn_pin = c; mosi_pin = m;
    repeat (n - 1) @(negedge clk);
  endtask

  int last_rise_cyc;

  task automatic send_byte(input logic [7:0] v, input int lo, input int hi);
    for (int i = 7; i >= 0; i--) begin
      put(1'b0, 1'b0, v[i], lo);
      if (i == 0) begin
        @(negedge clk);
        last_rise_cyc = cyc;
        sck_pin = 1'b1;
        repeat (hi - 1) @(negedge clk);
      end else begin
        put(1'b1, 1'b0, v[i], hi);
      end
    end
  endtask

  task automatic clear_log();
    got_b.delete(); got_f.delete(); got_c.delete();
  endtask

  task automatic end_frame();
    put(1'b0, 1'b0, 1'b0, 2);
    put(1'b0, 1'b1, 1'b0, 6);
  endtask

  initial begin
    rst_n = 1'b0;
    sck_pin = 1'b0; csn_pin = 1'b1; mosi_pin = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(byte_out == 8'h00, "R8", "byte_out in reset", byte_out, 0);
    chk(byte_valid == 1'b0, "R8", "valid in reset", byte_valid, 0);
    chk(byte_first == 1'b0, "R8", "first in reset", byte_first, 0);
    rst_n = 1'b1;
    put(1'b0, 1'b1, 1'b0, 4);

    // R9 R6 R1: three back-to-back bytes at 4 clocks per SCK period
    clear_log();
    put(1'b0, 1'b0, 1'b0, 2);
    send_byte(8'hA5, 2, 2);
    send_byte(8'h3C, 2, 2);
    send_byte(8'hFF, 2, 2);
    end_frame();
    chk(got_b.size() == 3, "R9", "byte count fast frame", got_b.size(), 3);
    if (got_b.size() == 3) begin
      chk(got_b[0] == 8'hA5, "R9", "fast byte 0", got_b[0], 8'hA5);
      chk(got_b[1] == 8'h3C, "R9", "fast byte 1", got_b[1], 8'h3C);
      chk(got_b[2] == 8'hFF, "R9", "fast byte 2", got_b[2], 8'hFF);
      chk(got_f[0] == 1'b1, "R6", "first flag byte 0", got_f[0], 1);
      chk(got_f[1] == 1'b0 && got_f[2] == 1'b0, "R6", "first flag later", {got_f[1], got_f[2]}, 0);
      chk(got_c[2] - last_rise_cyc == 3, "R1", "latency from 8th rise", got_c[2] - last_rise_cyc, 3);
    end

    // R2: slow SCK with long high phase, MSB first
    clear_log();
    put(1'b0, 1'b0, 1'b0, 3);
    send_byte(8'h81, 3, 7);
    end_frame();
    chk(got_b.size() == 1, "R2", "byte count slow sck", got_b.size(), 1);
    if (got_b.size() == 1) chk(got_b[0] == 8'h81, "R2", "slow byte", got_b[0], 8'h81);

    // R3: SCK toggling while chip select high
    clear_log();
    for (int i = 0; i < 16; i++) begin
      put(1'b1, 1'b1, 1'b1, 2);
      put(1'b0, 1'b1, 1'b0, 2);
    end
    put(1'b0, 1'b1, 1'b0, 4);
    chk(got_b.size() == 0, "R3", "no byte with cs high", got_b.size(), 0);
    chk(byte_out == 8'h81, "R3", "byte_out held", byte_out, 8'h81);

    // R3: chip-select fall coincident with SCK rise is not counted
    clear_log();
    put(1'b1, 1'b0, 1'b1, 2);
    send_byte(8'h5A, 2, 2);
    end_frame();
    chk(got_b.size() == 1, "R3", "byte count coincident fall", got_b.size(), 1);
    if (got_b.size() == 1) chk(got_b[0] == 8'h5A, "R3", "coincident byte", got_b[0], 8'h5A);

    // R7: partial byte dropped, next frame starts clean
    clear_log();
    put(1'b0, 1'b0, 1'b1, 2);
    for (int i = 0; i < 5; i++) begin
      put(1'b0, 1'b0, 1'b1, 2);
      put(1'b1, 1'b0, 1'b1, 2);
    end
    end_frame();
    chk(got_b.size() == 0, "R7", "no strobe for partial", got_b.size(), 0);
    put(1'b0, 1'b0, 1'b0, 2);
    send_byte(8'h69, 2, 2);
    end_frame();
    chk(got_b.size() == 1, "R7", "byte count after partial", got_b.size(), 1);
    if (got_b.size() == 1) begin
      chk(got_b[0] == 8'h69, "R7", "byte after partial", got_b[0], 8'h69);
      chk(got_f[0] == 1'b1, "R7", "first flag after partial", got_f[0], 1);
    end

    // R8: reset mid-frame discards collected bits
    clear_log();
    put(1'b0, 1'b0, 1'b1, 2);
    for (int i = 0; i < 4; i++) begin
      put(1'b0, 1'b0, 1'b1, 2);
      put(1'b1, 1'b0, 1'b1, 2);
    end
    put(1'b0, 1'b0, 1'b0, 1);
    rst_n = 1'b0;
    put(1'b0, 1'b0, 1'b0, 2);
    chk(byte_out == 8'h00, "R8", "byte_out after mid reset", byte_out, 0);
    rst_n = 1'b1;
    put(1'b0, 1'b0, 1'b0, 3);
    send_byte(8'hC3, 2, 2);
    end_frame();
    chk(got_b.size() == 1, "R8", "byte count after reset", got_b.size(), 1);
    if (got_b.size() == 1) begin
      chk(got_b[0] == 8'hC3, "R8", "byte after reset", got_b[0], 8'hC3);
      chk(got_f[0] == 1'b1, "R8", "first after reset", got_f[0], 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule